// File: doc/BRIEF.md
# Asynchronous Serial Engine with Parity and Channel Modes

This block is the bit-level core of an asynchronous serial port. It sends and receives 8-bit characters framed by one start bit (0) and one stop bit (1), with an optional parity bit after the data. Data goes out least significant bit first. Every bit lasts 16 pulses of a baud tick input that runs at sixteen times the bit rate. The transmitter has one holding register in front of its shift register. The receiver returns each character as a byte with a one-cycle valid pulse. Parity, framing and overrun problems are reported as one-cycle pulses that coincide with that valid pulse.

Each direction has its own enable, disable and reset strobes. A disable lets work already started finish before the side stops. A reset abandons the work at once. A channel mode select reroutes the serial pins so that the part can echo what it hears or loop data back on either side.

Top module: `uart_serial_engine`

## Requirements
- R1: After the reset input is released, both directions are disabled, `tx_pin` is 1, `tx_hold_empty` is 0 and `rx_valid` is 0.
- R2: A transmitted frame is a 0 start bit, then 8 data bits LSB first, then the parity bit when parity is on, then a 1 stop bit. Each bit lasts 16 baud ticks.
- R3: `par_sel` selects the parity bit: 0 makes the total number of ones even, 1 makes it odd, 2 sends a constant 0, 3 sends a constant 1, and 4 to 7 send no parity bit.
- R4: A write with `tx_wr` is accepted only while `tx_hold_empty` is 1, and `tx_hold_empty` then drops in the next cycle. An idle transmitter starts the held character at once. A character that is waiting when a stop bit ends starts immediately, with no idle time between the frames.
- R5: The receiver treats a low line as a start bit and checks it again 8 ticks later. It samples each following bit 16 ticks after the previous sample. It returns the byte on `rx_data` with a single-cycle `rx_valid` pulse.
- R6: `rx_par_err` pulses with `rx_valid` when the received parity bit differs from the value that `par_sel` calls for (codes 0 to 3). It never pulses when parity is off.
- R7: `rx_frm_err` pulses with `rx_valid` when the stop bit is sampled as 0.
- R8: `rx_ovr_err` pulses with `rx_valid` when a character completes before the previous one was acknowledged with `rx_rd`. The new byte replaces the old one on `rx_data`.
- R9: `rx_dis` lets a character already in progress complete and then stops the receiver. `rx_rst` abandons the character in progress, produces no `rx_valid` for it, and leaves the receiver disabled.
- R10: `tx_dis` lets the character being shifted and a character waiting in the holding register both go out, then stops the transmitter and refuses further writes. `tx_rst` returns the line to 1 in the next cycle, drops any waiting character and leaves the transmitter disabled.
- R11: `chan_mode` 1 (echo) drives `tx_pin` directly from `rx_pin`, and received characters are still delivered.
- R12: `chan_mode` 2 (local loopback) keeps `tx_pin` at 1 and feeds the transmitter's output to the receiver.
- R13: `chan_mode` 3 (remote loopback) drives `tx_pin` from `rx_pin`, and the receiver sees an idle line and delivers nothing. `chan_mode` 0 connects the transmitter to `tx_pin` and `rx_pin` to the receiver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| par_sel | input | 3 | Parity selection |
| chan_mode | input | 2 | Pin routing selection |
| tx_en | input | 1 | Transmitter enable strobe |
| tx_dis | input | 1 | Transmitter graceful disable strobe |
| tx_rst | input | 1 | Transmitter abort strobe |
| tx_wr | input | 1 | Write strobe for the holding register |
| tx_data | input | 8 | Character to send |
| tx_hold_empty | output | 1 | Holding register can take a character |
| tx_pin | output | 1 | Serial output line |
| rx_en | input | 1 | Receiver enable strobe |
| rx_dis | input | 1 | Receiver graceful disable strobe |
| rx_rst | input | 1 | Receiver abort strobe |
| rx_rd | input | 1 | Acknowledge of the last received byte |
| rx_pin | input | 1 | Serial input line |
| rx_data | output | 8 | Last received character |
| rx_valid | output | 1 | One-cycle pulse when a character completes |
| rx_par_err | output | 1 | Parity error pulse |
| rx_frm_err | output | 1 | Framing error pulse |
| rx_ovr_err | output | 1 | Overrun error pulse |

## Verification
The bench measures the start-to-start distance of two characters written back to back. A design that waited in idle after a stop bit would lengthen that distance by at least one tick. The bench issues a disable while one character is shifting and another is waiting, and checks that exactly two frames appear and that a later write is refused. A design that aborts on disable would lose the waiting character. The bench sends wrong parity bits under odd and forced-one parity, and a short stop bit followed by an idle line. A receiver that reports parity errors when parity is off, or that treats the tail of a short stop bit as a new character, shows up as extra or wrongly flagged bytes. In the routing modes the bench checks that the pin stays high under local loopback and that nothing is delivered under remote loopback.

// File: rtl/uart_eng_pkg.sv
package uart_eng_pkg;

  typedef enum logic [2:0] {
    FR_IDLE  = 3'd0,
    FR_START = 3'd1,
    FR_DATA  = 3'd2,
    FR_PAR   = 3'd3,
    FR_STOP  = 3'd4
  } frame_st_e;

  localparam logic [1:0] CH_NORMAL = 2'd0;
  localparam logic [1:0] CH_ECHO   = 2'd1;
  localparam logic [1:0] CH_LOCAL  = 2'd2;
  localparam logic [1:0] CH_REMOTE = 2'd3;

  // parity codes 0..3 carry a parity bit, anything above is none
  function automatic logic par_on(input logic [2:0] sel);
    return sel < 3'd4;
  endfunction

  // expected parity bit given the xor of all data bits
  function automatic logic par_bit(input logic [2:0] sel, input logic ones_odd);
    logic r;
    case (sel)
      3'd0:    r = ones_odd;
      3'd1:    r = ~ones_odd;
      3'd2:    r = 1'b0;
      3'd3:    r = 1'b1;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/uart_sync.sv
module uart_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  generate
    if (STAGES <= 1) begin : g_one
      logic ff_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= 1'b1;
        else        ff_q <= d;
      end
      assign q = ff_q;
    end else begin : g_chain
      logic [STAGES-1:0] ff_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '1;
        else        ff_q <= {ff_q[STAGES-2:0], d};
      end
      assign q = ff_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/uart_chan_mux.sv
module uart_chan_mux
  import uart_eng_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       tx_line,
  input  logic       pin_in,
  output logic       pin_out,
  output logic       rx_src
);

  always_comb begin
    pin_out = tx_line;
    rx_src  = pin_in;
    case (mode)
      CH_ECHO: begin
        pin_out = pin_in;
        rx_src  = pin_in;
      end
      CH_LOCAL: begin
        pin_out = 1'b1;
        rx_src  = tx_line;
      end
      CH_REMOTE: begin
        pin_out = pin_in;
        rx_src  = 1'b1;
      end
      default: begin
        pin_out = tx_line;
        rx_src  = pin_in;
      end
    endcase
  end

endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path
  import uart_eng_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [2:0]        par_sel,
  input  logic              en,
  input  logic              dis,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              hold_empty,
  output logic              line
);

  localparam int CNT_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  frame_st_e         st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              pb_q, pb_n;
  logic [DATA_W-1:0] hold_q, hold_n;
  logic              full_q, full_n;
  logic              on_q, on_n;
  logic              halt_q, halt_n;
  logic              bit_end;
  logic              load;

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    idx_n   = idx_q;
    sh_n    = sh_q;
    pb_n    = pb_q;
    hold_n  = hold_q;
    full_n  = full_q;
    on_n    = on_q;
    halt_n  = halt_q;
    load    = 1'b0;
    bit_end = tick && (cnt_q == CNT_LAST);

    if (tick && (st_q != FR_IDLE)) begin
      cnt_n = bit_end ? '0 : cnt_q + 1'b1;
    end

    case (st_q)
      FR_IDLE: begin
        load = full_q && on_q;
      end
      FR_START: begin
        if (bit_end) begin
          st_n  = FR_DATA;
          idx_n = '0;
        end
      end
      FR_DATA: begin
        if (bit_end) begin
          sh_n  = sh_q >> 1;
          idx_n = idx_q + 1'b1;
          if (idx_q == IDX_LAST) begin
            st_n = par_on(par_sel) ? FR_PAR : FR_STOP;
          end
        end
      end
      FR_PAR: begin
        if (bit_end) st_n = FR_STOP;
      end
      FR_STOP: begin
        if (bit_end) begin
          if (full_q && on_q) load = 1'b1;
          else                st_n = FR_IDLE;
        end
      end
      default: st_n = FR_IDLE;
    endcase

    // move the held character into the shifter
    if (load) begin
      st_n   = FR_START;
      cnt_n  = '0;
      sh_n   = hold_q;
      pb_n   = par_bit(par_sel, ^hold_q);
      full_n = 1'b0;
    end

    if (wr && on_q && !halt_q && !full_q) begin
      hold_n = wdata;
      full_n = 1'b1;
    end

    // graceful stop once nothing is left to send
    if (halt_q && (st_q == FR_IDLE) && !full_q) begin
      on_n   = 1'b0;
      halt_n = 1'b0;
    end

    if (dis) begin
      halt_n = on_q;
    end else if (en) begin
      on_n   = 1'b1;
      halt_n = 1'b0;
    end

    if (rst) begin
      st_n   = FR_IDLE;
      cnt_n  = '0;
      full_n = 1'b0;
      on_n   = 1'b0;
      halt_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_n_reg_reset();
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      idx_q  <= idx_n;
      sh_q   <= sh_n;
      pb_q   <= pb_n;
      hold_q <= hold_n;
      full_q <= full_n;
      on_q   <= on_n;
      halt_q <= halt_n;
    end
  end

  task automatic st_n_reg_reset();
    st_q   <= FR_IDLE;
    cnt_q  <= '0;
    idx_q  <= '0;
    sh_q   <= '0;
    pb_q   <= 1'b0;
    hold_q <= '0;
    full_q <= 1'b0;
    on_q   <= 1'b0;
    halt_q <= 1'b0;
  endtask

  always_comb begin
    case (st_q)
      FR_START: line = 1'b0;
      FR_DATA:  line = sh_q[0];
      FR_PAR:   line = pb_q;
      default:  line = 1'b1;
    endcase
  end

  assign hold_empty = on_q && !halt_q && !full_q;

endmodule

// File: rtl/uart_rx_path.sv
module uart_rx_path
  import uart_eng_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [2:0]        par_sel,
  input  logic              en,
  input  logic              dis,
  input  logic              rst,
  input  logic              rd,
  input  logic              line,
  output logic [DATA_W-1:0] data,
  output logic              valid,
  output logic              perr,
  output logic              ferr,
  output logic              oerr
);

  localparam int CNT_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVS / 2 - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  frame_st_e         st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              acc_q, acc_n;
  logic              bad_q, bad_n;
  logic              on_q, on_n;
  logic              halt_q, halt_n;
  logic              unread_q, unread_n;
  logic [DATA_W-1:0] dat_q, dat_n;
  logic              vld_q, vld_n;
  logic              perr_q, perr_n;
  logic              ferr_q, ferr_n;
  logic              oerr_q, oerr_n;
  logic              bit_end;
  logic              mid;
  logic              done;

  always_comb begin
    st_n     = st_q;
    cnt_n    = cnt_q;
    idx_n    = idx_q;
    sh_n     = sh_q;
    acc_n    = acc_q;
    bad_n    = bad_q;
    on_n     = on_q;
    halt_n   = halt_q;
    unread_n = unread_q;
    dat_n    = dat_q;
    vld_n    = 1'b0;
    perr_n   = 1'b0;
    ferr_n   = 1'b0;
    oerr_n   = 1'b0;
    done     = 1'b0;
    bit_end  = tick && (cnt_q == CNT_LAST);
    mid      = tick && (cnt_q == CNT_MID);

    if (tick && (st_q != FR_IDLE)) begin
      cnt_n = cnt_q + 1'b1;
    end

    case (st_q)
      FR_IDLE: begin
        if (tick && on_q && !halt_q && !line) begin
          st_n  = FR_START;
          cnt_n = '0;
        end
      end
      FR_START: begin
        if (mid) begin
          cnt_n = '0;
          if (!line) begin
            st_n  = FR_DATA;
            idx_n = '0;
            acc_n = 1'b0;
            bad_n = 1'b0;
          end else begin
            st_n = FR_IDLE;
          end
        end
      end
      FR_DATA: begin
        if (bit_end) begin
          cnt_n = '0;
          sh_n  = {line, sh_q[DATA_W-1:1]};
          acc_n = acc_q ^ line;
          idx_n = idx_q + 1'b1;
          if (idx_q == IDX_LAST) begin
            st_n = par_on(par_sel) ? FR_PAR : FR_STOP;
          end
        end
      end
      FR_PAR: begin
        if (bit_end) begin
          cnt_n = '0;
          bad_n = (line != par_bit(par_sel, acc_q));
          st_n  = FR_STOP;
        end
      end
      FR_STOP: begin
        if (bit_end) begin
          cnt_n = '0;
          st_n  = FR_IDLE;
          done  = 1'b1;
        end
      end
      default: st_n = FR_IDLE;
    endcase

    if (done) begin
      vld_n    = 1'b1;
      dat_n    = sh_q;
      ferr_n   = !line;
      perr_n   = bad_q;
      oerr_n   = unread_q;
      unread_n = 1'b1;
    end else if (rd) begin
      unread_n = 1'b0;
    end

    if (halt_q && (st_q == FR_IDLE)) begin
      on_n   = 1'b0;
      halt_n = 1'b0;
    end

    if (dis) begin
      halt_n = on_q;
    end else if (en) begin
      on_n   = 1'b1;
      halt_n = 1'b0;
    end

    if (rst) begin
      st_n   = FR_IDLE;
      cnt_n  = '0;
      on_n   = 1'b0;
      halt_n = 1'b0;
      vld_n  = 1'b0;
      perr_n = 1'b0;
      ferr_n = 1'b0;
      oerr_n = 1'b0;
      dat_n  = dat_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= FR_IDLE;
      cnt_q    <= '0;
      idx_q    <= '0;
      sh_q     <= '0;
      acc_q    <= 1'b0;
      bad_q    <= 1'b0;
      on_q     <= 1'b0;
      halt_q   <= 1'b0;
      unread_q <= 1'b0;
      dat_q    <= '0;
      vld_q    <= 1'b0;
      perr_q   <= 1'b0;
      ferr_q   <= 1'b0;
      oerr_q   <= 1'b0;
    end else begin
      st_q     <= st_n;
      cnt_q    <= cnt_n;
      idx_q    <= idx_n;
      sh_q     <= sh_n;
      acc_q    <= acc_n;
      bad_q    <= bad_n;
      on_q     <= on_n;
      halt_q   <= halt_n;
      unread_q <= unread_n;
      dat_q    <= dat_n;
      vld_q    <= vld_n;
      perr_q   <= perr_n;
      ferr_q   <= ferr_n;
      oerr_q   <= oerr_n;
    end
  end

  assign data  = dat_q;
  assign valid = vld_q;
  assign perr  = perr_q;
  assign ferr  = ferr_q;
  assign oerr  = oerr_q;

endmodule

// File: rtl/uart_serial_engine.sv
module uart_serial_engine #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic [2:0]        par_sel,
  input  logic [1:0]        chan_mode,
  input  logic              tx_en,
  input  logic              tx_dis,
  input  logic              tx_rst,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_hold_empty,
  output logic              tx_pin,
  input  logic              rx_en,
  input  logic              rx_dis,
  input  logic              rx_rst,
  input  logic              rx_rd,
  input  logic              rx_pin,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_par_err,
  output logic              rx_frm_err,
  output logic              rx_ovr_err
);

  logic tx_line;
  logic rx_src;
  logic rx_line;

  uart_tx_path #(
    .DATA_W (DATA_W),
    .OVS    (OVS)
  ) i_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (baud_tick),
    .par_sel    (par_sel),
    .en         (tx_en),
    .dis        (tx_dis),
    .rst        (tx_rst),
    .wr         (tx_wr),
    .wdata      (tx_data),
    .hold_empty (tx_hold_empty),
    .line       (tx_line)
  );

  uart_chan_mux i_mux (
    .mode    (chan_mode),
    .tx_line (tx_line),
    .pin_in  (rx_pin),
    .pin_out (tx_pin),
    .rx_src  (rx_src)
  );

  uart_sync #(
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rx_src),
    .q     (rx_line)
  );

  uart_rx_path #(
    .DATA_W (DATA_W),
    .OVS    (OVS)
  ) i_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (baud_tick),
    .par_sel (par_sel),
    .en      (rx_en),
    .dis     (rx_dis),
    .rst     (rx_rst),
    .rd      (rx_rd),
    .line    (rx_line),
    .data    (rx_data),
    .valid   (rx_valid),
    .perr    (rx_par_err),
    .ferr    (rx_frm_err),
    .oerr    (rx_ovr_err)
  );

endmodule

// File: rtl/uart_serial_engine_chk.sv
module uart_serial_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] chan_mode,
  input logic       tx_rst,
  input logic       tx_wr,
  input logic       tx_hold_empty,
  input logic       tx_pin,
  input logic       tx_line,
  input logic       rx_pin,
  input logic       rx_rst,
  input logic       rx_valid,
  input logic       rx_par_err,
  input logic       rx_frm_err,
  input logic       rx_ovr_err
);

  // R4
  hold_takes_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_hold_empty) |=> !tx_hold_empty);

  // R5
  valid_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R6
  par_err_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_par_err |-> rx_valid);

  // R7
  frm_err_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frm_err |-> rx_valid);

  // R8
  ovr_err_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovr_err |-> rx_valid);

  // R9
  rx_abort_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst |=> !rx_valid);

  // R10
  tx_abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst |=> (tx_line && !tx_hold_empty));

  // R11
  echo_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_mode == 2'd1) |-> (tx_pin == rx_pin));

  // R12
  local_pin_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_mode == 2'd2) |-> tx_pin);

  // R13
  remote_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_mode == 2'd3) |-> (tx_pin == rx_pin));

endmodule

bind uart_serial_engine uart_serial_engine_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .chan_mode     (chan_mode),
  .tx_rst        (tx_rst),
  .tx_wr         (tx_wr),
  .tx_hold_empty (tx_hold_empty),
  .tx_pin        (tx_pin),
  .tx_line       (tx_line),
  .rx_pin        (rx_pin),
  .rx_rst        (rx_rst),
  .rx_valid      (rx_valid),
  .rx_par_err    (rx_par_err),
  .rx_frm_err    (rx_frm_err),
  .rx_ovr_err    (rx_ovr_err)
);

// File: tb/test_uart_serial_engine.sv
module test_uart_serial_engine;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT        = 16 * TICK_DIV;

  logic       clk;
  logic       rst_n;
  logic       baud_tick;
  logic [2:0] par_sel;
  logic [1:0] chan_mode;
  logic       tx_en, tx_dis, tx_rst, tx_wr;
  logic [7:0] tx_data;
  logic       tx_hold_empty, tx_pin;
  logic       rx_en, rx_dis, rx_rst, rx_rd, rx_pin;
  logic [7:0] rx_data;
  logic       rx_valid, rx_par_err, rx_frm_err, rx_ovr_err;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int tdiv = 0;
  bit finished = 0;

  logic       mon_en = 1'b0;
  logic       mon_par = 1'b1;
  logic       must_idle = 1'b0;
  logic [9:0] tx_q[$];
  int         tx_t[$];
  logic [10:0] rx_q[$];

  uart_serial_engine i_uart_serial_engine (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .par_sel(par_sel), .chan_mode(chan_mode),
    .tx_en(tx_en), .tx_dis(tx_dis), .tx_rst(tx_rst), .tx_wr(tx_wr),
    .tx_data(tx_data), .tx_hold_empty(tx_hold_empty), .tx_pin(tx_pin),
    .rx_en(rx_en), .rx_dis(rx_dis), .rx_rst(rx_rst), .rx_rd(rx_rd),
    .rx_pin(rx_pin), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_ovr_err(rx_ovr_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    tdiv <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    baud_tick <= (tdiv == TICK_DIV - 1);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic ref_par(input logic [2:0] sel, input logic [7:0] d);
    case (sel)
      3'd0: return ^d;
      3'd1: return ~^d;
      3'd2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  // transmit line decoder
  initial begin
    logic [7:0] d;
    logic p, s;
    int t0;
    forever begin
      @(negedge clk);
      if (mon_en && tx_pin === 1'b0) begin
        t0 = cyc;
        repeat (BIT / 2) @(negedge clk);
        if (tx_pin === 1'b0) begin
          for (int i = 0; i < 8; i++) begin
            repeat (BIT) @(negedge clk);
            d[i] = tx_pin;
          end
          p = 1'b0;
          if (mon_par) begin
            repeat (BIT) @(negedge clk);
            p = tx_pin;
          end
          repeat (BIT) @(negedge clk);
          s = tx_pin;
          tx_q.push_back({s, p, d});
          tx_t.push_back(t0);
        end
      end
    end
  end

  // receive side collector and per-clock idle comparison
  always @(negedge clk) begin
    if (rst_n && rx_valid)
      rx_q.push_back({rx_ovr_err, rx_frm_err, rx_par_err, rx_data});
    if (rst_n && must_idle && tx_pin !== 1'b1) begin
      checks++;
      failures++;
      $display("FAIL R12 actual=%0h expected=1", tx_pin);
    end
  end

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tx_en();  @(negedge clk); tx_en = 1; @(negedge clk); tx_en = 0; endtask
  task automatic pulse_tx_dis(); @(negedge clk); tx_dis = 1; @(negedge clk); tx_dis = 0; endtask
  task automatic pulse_rx_en();  @(negedge clk); rx_en = 1; @(negedge clk); rx_en = 0; endtask
  task automatic pulse_rx_dis(); @(negedge clk); rx_dis = 1; @(negedge clk); rx_dis = 0; endtask
  task automatic pulse_rx_rst(); @(negedge clk); rx_rst = 1; @(negedge clk); rx_rst = 0; endtask
  task automatic pulse_rd();     @(negedge clk); rx_rd = 1; @(negedge clk); rx_rd = 0; endtask

  task automatic write_byte(input logic [7:0] d);
    for (int k = 0; k < 4000 && tx_hold_empty !== 1'b1; k++) @(negedge clk);
    tx_data = d;
    tx_wr = 1;
    @(negedge clk);
    tx_wr = 0;
  endtask

  task automatic wait_frames(input int n);
    for (int k = 0; k < 4000 && tx_q.size() < n; k++) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] d, input logic [2:0] sel,
                         input bit flip, input bit stop_v);
    @(negedge clk);
    rx_pin = 0;
    clks(BIT);
    for (int i = 0; i < 8; i++) begin
      rx_pin = d[i];
      clks(BIT);
    end
    if (sel < 3'd4) begin
      rx_pin = ref_par(sel, d) ^ flip;
      clks(BIT);
    end
    rx_pin = stop_v;
    clks(stop_v ? BIT : (BIT * 3) / 4);
    rx_pin = 1;
    clks(BIT);
  endtask

  task automatic check_tx_frame(input int idx, input string req, input logic [7:0] d,
                                input logic [2:0] sel);
    logic [9:0] f;
    if (tx_q.size() <= idx) begin
      check(0, req, tx_q.size(), idx + 1);
    end else begin
      f = tx_q[idx];
      check(f[7:0] == d, req, f[7:0], d);
      check(f[9] == 1'b1, req, f[9], 1);
      if (sel < 3'd4) check(f[8] == ref_par(sel, d), req, f[8], ref_par(sel, d));
    end
  endtask

  task automatic check_rx(input string req, input logic [7:0] d, input logic [2:0] errs);
    if (rx_q.size() != 1) begin
      check(0, req, rx_q.size(), 1);
    end else begin
      check(rx_q[0][7:0] == d, req, rx_q[0][7:0], d);
      check(rx_q[0][10:8] == errs, req, rx_q[0][10:8], errs);
    end
  endtask

  initial begin
    rst_n = 0; baud_tick = 0; par_sel = 0; chan_mode = 0;
    tx_en = 0; tx_dis = 0; tx_rst = 0; tx_wr = 0; tx_data = 0;
    rx_en = 0; rx_dis = 0; rx_rst = 0; rx_rd = 0; rx_pin = 1;
    clks(5);
    rst_n = 1;
    clks(3);
    // R1 reset state
    check(tx_pin === 1'b1, "R1", tx_pin, 1);
    check(tx_hold_empty === 1'b0, "R1", tx_hold_empty, 0);
    check(rx_valid === 1'b0, "R1", rx_valid, 0);

    pulse_tx_en();
    pulse_rx_en();
    mon_en = 1;

    // R2 even parity frame
    tx_q.delete(); tx_t.delete();
    write_byte(8'hA5);
    wait_frames(1);
    check_tx_frame(0, "R2", 8'hA5, 3'd0);

    // R3 every other parity code
    for (int s = 1; s <= 4; s++) begin
      logic [7:0] b;
      b = (s == 1) ? 8'h3C : (s == 2) ? 8'h81 : (s == 3) ? 8'h00 : 8'h7E;
      par_sel = 3'(s);
      mon_par = (s < 4);
      clks(4);
      tx_q.delete(); tx_t.delete();
      write_byte(b);
      wait_frames(1);
      check_tx_frame(0, "R3", b, 3'(s));
    end

    // R4 back to back characters
    par_sel = 0; mon_par = 1;
    clks(2 * BIT);
    tx_q.delete(); tx_t.delete();
    write_byte(8'h11);
    write_byte(8'h22);
    wait_frames(2);
    check_tx_frame(0, "R4", 8'h11, 3'd0);
    check_tx_frame(1, "R4", 8'h22, 3'd0);
    if (tx_t.size() >= 2) begin
      int gap;
      gap = tx_t[1] - tx_t[0];
      check(gap >= 11 * BIT - 2 * TICK_DIV && gap <= 11 * BIT + 1, "R4", gap, 11 * BIT);
    end

    // R5 plain reception
    rx_q.delete();
    send_rx(8'h5A, 3'd0, 0, 1);
    clks(4);
    check_rx("R5", 8'h5A, 3'b000);
    pulse_rd();

    // R6 parity error cases
    par_sel = 3'd1; rx_q.delete();
    send_rx(8'hC4, 3'd1, 1, 1); clks(4);
    check_rx("R6", 8'hC4, 3'b001); pulse_rd();
    par_sel = 3'd3; rx_q.delete();
    send_rx(8'h19, 3'd3, 1, 1); clks(4);
    check_rx("R6", 8'h19, 3'b001); pulse_rd();
    par_sel = 3'd2; rx_q.delete();
    send_rx(8'hE7, 3'd2, 0, 1); clks(4);
    check_rx("R6", 8'hE7, 3'b000); pulse_rd();
    par_sel = 3'd4; rx_q.delete();
    send_rx(8'h6B, 3'd4, 0, 1); clks(4);
    check_rx("R6", 8'h6B, 3'b000); pulse_rd();

    // R7 short low stop bit
    par_sel = 3'd0; rx_q.delete();
    send_rx(8'h2D, 3'd0, 0, 0); clks(2 * BIT);
    check_rx("R7", 8'h2D, 3'b010); pulse_rd();

    // R8 overrun and overwrite
    rx_q.delete();
    send_rx(8'h01, 3'd0, 0, 1);
    send_rx(8'h02, 3'd0, 0, 1);
    clks(4);
    check(rx_q.size() == 2, "R8", rx_q.size(), 2);
    if (rx_q.size() == 2) begin
      check(rx_q[0][10] == 1'b0, "R8", rx_q[0][10], 0);
      check(rx_q[1][10] == 1'b1, "R8", rx_q[1][10], 1);
      check(rx_data == 8'h02, "R8", rx_data, 8'h02);
    end
    pulse_rd();

    // R9 graceful receiver disable
    rx_q.delete();
    fork
      send_rx(8'h33, 3'd0, 0, 1);
      begin clks(3 * BIT); pulse_rx_dis(); end
    join
    clks(4);
    check_rx("R9", 8'h33, 3'b000); pulse_rd();
    rx_q.delete();
    send_rx(8'h44, 3'd0, 0, 1); clks(4);
    check(rx_q.size() == 0, "R9", rx_q.size(), 0);
    pulse_rx_en();
    // R9 receiver abort
    rx_q.delete();
    fork
      send_rx(8'h55, 3'd0, 0, 1);
      begin clks(4 * BIT); pulse_rx_rst(); end
    join
    send_rx(8'h56, 3'd0, 0, 1); clks(4);
    check(rx_q.size() == 0, "R9", rx_q.size(), 0);
    pulse_rx_en();

    // R10 graceful transmitter disable with one waiting
    tx_q.delete(); tx_t.delete();
    write_byte(8'h61);
    write_byte(8'h62);
    pulse_tx_dis();
    wait_frames(2);
    clks(2 * BIT);
    check_tx_frame(0, "R10", 8'h61, 3'd0);
    check_tx_frame(1, "R10", 8'h62, 3'd0);
    check(tx_hold_empty === 1'b0, "R10", tx_hold_empty, 0);
    @(negedge clk); tx_data = 8'h63; tx_wr = 1; @(negedge clk); tx_wr = 0;
    clks(14 * BIT);
    check(tx_q.size() == 2, "R10", tx_q.size(), 2);
    pulse_tx_en();
    // R10 transmitter abort
    write_byte(8'h70);
    clks(3 * BIT);
    mon_en = 0;
    @(negedge clk); tx_rst = 1; @(negedge clk); tx_rst = 0;
    check(tx_pin === 1'b1, "R10", tx_pin, 1);
    check(tx_hold_empty === 1'b0, "R10", tx_hold_empty, 0);
    clks(12 * BIT);
    tx_q.delete(); tx_t.delete();
    mon_en = 1;
    pulse_tx_en();

    // R11 echo routing
    chan_mode = 2'd1;
    @(negedge clk); rx_pin = 0; #1;
    check(tx_pin === 1'b0, "R11", tx_pin, 0);
    rx_pin = 1;
    rx_q.delete(); tx_q.delete();
    send_rx(8'h96, 3'd0, 0, 1); clks(4);
    check_rx("R11", 8'h96, 3'b000); pulse_rd();
    check_tx_frame(0, "R11", 8'h96, 3'd0);

    // R12 local loopback
    chan_mode = 2'd2;
    clks(4);
    rx_q.delete(); tx_q.delete();
    must_idle = 1;
    write_byte(8'hC3);
    clks(13 * BIT);
    must_idle = 0;
    check(tx_q.size() == 0, "R12", tx_q.size(), 0);
    check_rx("R12", 8'hC3, 3'b000); pulse_rd();

    // R13 remote loopback
    chan_mode = 2'd3;
    clks(4);
    rx_q.delete(); tx_q.delete();
    send_rx(8'h0F, 3'd0, 0, 1); clks(4);
    check(rx_q.size() == 0, "R13", rx_q.size(), 0);
    check_tx_frame(0, "R13", 8'h0F, 3'd0);

    // R13 normal routing restored
    chan_mode = 2'd0;
    clks(4);
    tx_q.delete();
    write_byte(8'hB2);
    wait_frames(1);
    check_tx_frame(0, "R13", 8'hB2, 3'd0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule